// File: doc/BRIEF.md
# Banked RAM with Chip-Select Decoding

This block assembles one large random-access memory out of a grid of identical small RAM banks. The upper address bits go to a decoder, which raises exactly one chip select. The lower address bits reach every bank at the same time. The word is widened by placing several bank columns next to each other on shared address and control lines, and each column stores its own slice of the data word. Reads are combinational. A write takes effect on the rising clock edge and reaches only the bank row that the decoder has selected.

The bank rows share one read bus. On a board that bus would be tri-stated. Here it is an AND-OR merge gated by the one-hot chip selects, so only the selected row contributes to the output. Parameters set the bank depth (as address bits), the slice width, the number of bank rows and the number of columns. The defaults give 4 rows of 2 columns, each bank 64 words of 8 bits. That is a 256-word by 16-bit memory with an 8-bit address.

Top module: `mbm_banked_mem`

## Requirements
- R1: `addr[ADDR_W-1 -: SEL_W]` picks the bank row and `addr[BANK_AW-1:0]` picks the word inside it. Row i therefore holds addresses i*2^BANK_AW through (i+1)*2^BANK_AW-1.
- R2: At every moment exactly one chip select is active: the one whose index equals the upper address bits.
- R3: On a rising edge of `clk` with `we`=1 and `rst_n`=1, `din` is stored at `addr`. A read of that address afterwards returns it.
- R4: A write changes only the selected row. The same local offset in every other row keeps its previous value, so no row aliases another.
- R5: `dout` follows `addr` combinationally and shows the stored word with no clock edge in between. A written value is visible right after the writing edge.
- R6: The data word is WIDE_MUL slices of BANK_DW bits each. Slice s occupies `din`/`dout` bits [s*BANK_DW +: BANK_DW] and is held in its own bank column. All slices are written together, and each slice reads back independently of the others.
- R7: While `rst_n`=0, writes are suppressed and stored contents are neither cleared nor altered. Reads still return the stored data.
- R8: Writes to different rows on consecutive clock cycles both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | ADDR_W (8) | Word address: row select above, bank offset below |
| din | input | DATA_W (16) | Write data |
| we | input | 1 | Write enable |
| dout | output | DATA_W (16) | Combinational read data |

## Verification
The bench writes distinct patterns at the first and last word of every row and at one shared offset in all rows, then reads every location back. A decoder that dropped or swapped an upper address bit would make two rows alias, and a later write would show through at the wrong address. It overwrites one row and confirms the other rows still hold their values, which catches a write strobe that is not gated by the chip select. It also checks read data between clock edges, slice patterns that differ per column, back-to-back writes to different rows, and a write attempted during reset. A registered read path, a swapped column, or writes that ignore the reset would each show up as a mismatch in one of those checks.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  // Width of the row-select field for a given row count (at least 1).
  function automatic int sel_width(input int rows);
    return (rows < 2) ? 1 : $clog2(rows);
  endfunction

  // First global address covered by a bank row.
  function automatic int row_base(input int row, input int bank_aw);
    return row << bank_aw;
  endfunction

  // Last global address covered by a bank row.
  function automatic int row_last(input int row, input int bank_aw);
    return ((row + 1) << bank_aw) - 1;
  endfunction
endpackage

// File: rtl/mbm_cs_decode.sv
module mbm_cs_decode #(
  parameter int SEL_W = 2,
  parameter int ROWS  = 4
) (
  input  logic [SEL_W-1:0] row_idx,
  output logic [ROWS-1:0]  row_cs
);
  for (genvar i = 0; i < ROWS; i++) begin : g_cs
    assign row_cs[i] = (row_idx == SEL_W'(i));
  end
endmodule

// File: rtl/mbm_bank.sv
module mbm_bank #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_hit;

  assign wr_hit = cs & we & rst_n;

  always_ff @(posedge clk) begin
    if (wr_hit) mem[addr] <= din;
  end

  assign dout = mem[addr];

  // R3
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mem[$past(addr)] === $past(din)));

  // R4
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (mem[$past(addr)] === $past(mem[addr])));
endmodule

// File: rtl/mbm_read_merge.sv
module mbm_read_merge #(
  parameter int ROWS = 4,
  parameter int DW   = 16
) (
  input  logic [ROWS-1:0]    row_cs,
  input  logic [ROWS*DW-1:0] row_data,
  output logic [DW-1:0]      merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < ROWS; i++) begin
      merged = merged | (row_data[i*DW +: DW] & {DW{row_cs[i]}});
    end
  end
endmodule

// File: rtl/mbm_banked_mem.sv
module mbm_banked_mem #(
  parameter int BANK_AW   = 6,
  parameter int BANK_DW   = 8,
  parameter int NUM_BANKS = 4,
  parameter int WIDE_MUL  = 2,
  localparam int SEL_W    = mbm_pkg::sel_width(NUM_BANKS),
  localparam int ADDR_W   = BANK_AW + SEL_W,
  localparam int DATA_W   = BANK_DW * WIDE_MUL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we,
  output logic [DATA_W-1:0] dout
);
  // Named internal events for the checks below.
  logic [SEL_W-1:0]            row_idx;
  logic [BANK_AW-1:0]          row_off;
  logic [NUM_BANKS-1:0]        bank_cs;
  logic [NUM_BANKS-1:0]        bank_we;
  logic                        we_eff;
  logic [NUM_BANKS*DATA_W-1:0] rd_rows;

  assign row_idx = addr[ADDR_W-1 -: SEL_W];
  assign row_off = addr[BANK_AW-1:0];
  assign we_eff  = we & rst_n;

  mbm_cs_decode #(.SEL_W(SEL_W), .ROWS(NUM_BANKS)) u_dec (
    .row_idx (row_idx),
    .row_cs  (bank_cs)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    assign bank_we[b] = bank_cs[b] & we_eff;
    for (genvar s = 0; s < WIDE_MUL; s++) begin : g_col
      mbm_bank #(.AW(BANK_AW), .DW(BANK_DW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (bank_cs[b]),
        .we    (we_eff),
        .addr  (row_off),
        .din   (din[s*BANK_DW +: BANK_DW]),
        .dout  (rd_rows[b*DATA_W + s*BANK_DW +: BANK_DW])
      );
    end
  end

  mbm_read_merge #(.ROWS(NUM_BANKS), .DW(DATA_W)) u_merge (
    .row_cs   (bank_cs),
    .row_data (rd_rows),
    .merged   (dout)
  );

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_cs) == 1);

  // R1
  cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cs[row_idx] == 1'b1);

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we) && ((bank_we & ~bank_cs) == '0));

  // R5
  rd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout === rd_rows[row_idx*DATA_W +: DATA_W]);
endmodule

// File: tb/tb_mbm_banked_mem.sv
`timescale 1ns/100ps
module tb_mbm_banked_mem;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int ROWS  = 4;
  localparam int MUL   = 2;
  localparam int DEPTH = 1 << AW;
  localparam int ADW   = AW + 2;
  localparam int DTW   = DW * MUL;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [ADW-1:0] addr = '0;
  logic [DTW-1:0] din = '0;
  logic           we = 1'b0;
  logic [DTW-1:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DTW-1:0] ref_mem [int];

  always #2.5 clk = ~clk;

  mbm_banked_mem #(.BANK_AW(AW), .BANK_DW(DW), .NUM_BANKS(ROWS), .WIDE_MUL(MUL)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we(we), .dout(dout)
  );

  // Behavioural reference: a flat word array, written only outside reset.
  always @(posedge clk) begin
    if (rst_n && we) ref_mem[int'(addr)] = din;
  end

  task automatic chk(input string req, input logic [DTW-1:0] act, input logic [DTW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every clock: compare the output with the reference for known addresses (R5).
  always @(negedge clk) begin
    if (ref_mem.exists(int'(addr))) chk("R5", dout, ref_mem[int'(addr)]);
  end

  task automatic cyc(input int a, input logic [DTW-1:0] d, input logic w);
    @(posedge clk); #1;
    addr = ADW'(a); din = d; we = w;
  endtask

  task automatic rd(input int a, input logic [DTW-1:0] exp, input string req);
    cyc(a, '0, 1'b0);
    @(negedge clk);
    chk(req, dout, exp);
  endtask

  function automatic logic [DTW-1:0] pat(input int row, input int kind);
    logic [DTW-1:0] m;
    m = (kind == 0) ? 16'h5A5A : (kind == 1) ? 16'h0F0F : 16'hC3C3;
    return DTW'(row * 16'h1111) ^ m;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: a write during reset is dropped and contents survive reset
    cyc(5, 16'hAAAA, 1'b1);
    cyc(5, '0, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b0; addr = ADW'(5); din = 16'h1234; we = 1'b1;
    @(negedge clk); chk("R7", dout, 16'hAAAA);
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk); chk("R7", dout, 16'hAAAA);
    rst_n = 1'b1;
    rd(5, 16'hAAAA, "R7");

    // R1/R2: first and last word of every row, plus a shared offset
    for (int r = 0; r < ROWS; r++) begin
      cyc(r * DEPTH, pat(r, 0), 1'b1);
      cyc(r * DEPTH + DEPTH - 1, pat(r, 1), 1'b1);
      cyc(r * DEPTH + 10, pat(r, 2), 1'b1);
    end
    for (int r = 0; r < ROWS; r++) begin
      rd(r * DEPTH, pat(r, 0), "R1");
      rd(r * DEPTH + DEPTH - 1, pat(r, 1), "R2");
      rd(r * DEPTH + 10, pat(r, 2), "R4");
    end

    // R4: overwrite one row's shared offset; the others stay unchanged
    cyc(2 * DEPTH + 10, 16'hBEEF, 1'b1);
    for (int r = 0; r < ROWS; r++)
      rd(r * DEPTH + 10, (r == 2) ? 16'hBEEF : pat(r, 2), "R4");

    // R3: write, then read on the very next cycle
    cyc(33, 16'h7E57, 1'b1);
    rd(33, 16'h7E57, "R3");

    // R8: back-to-back writes to different rows
    cyc(DEPTH + 20, 16'h1357, 1'b1);
    cyc(3 * DEPTH + 20, 16'h2468, 1'b1);
    rd(DEPTH + 20, 16'h1357, "R8");
    rd(3 * DEPTH + 20, 16'h2468, "R8");

    // R6: each column holds its own slice
    cyc(40, 16'h00FF, 1'b1);
    cyc(41, 16'hFF00, 1'b1);
    rd(40, 16'h00FF, "R6");
    rd(41, 16'hFF00, "R6");

    // R5: address change between edges shows new data without a clock
    cyc(DEPTH - 1, '0, 1'b0);
    #0.5 chk("R5", dout, pat(0, 1));
    addr = ADW'(3 * DEPTH);
    #0.5 chk("R5", dout, pat(3, 0));

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule